// File: doc/BRIEF.md
# Page Write Staging and Timed Commit Unit

This block sits behind the serial protocol engine of a small byte-addressed non-volatile store. While a write transaction is in progress, the engine passes it two things: the memory address word once, then each data byte as it arrives. The block holds those bytes in an eight-slot page buffer. The low address bits select the starting slot, and the slot pointer advances with every byte. When the pointer passes the end of the page it wraps to the start of the same page, so any bytes beyond eight overwrite the earliest ones.

A stop strobe that arrives after at least one byte starts a timed write cycle. The cycle length is a parameter counted in clock cycles. During that window the `busy` output is high. The engine uses `busy` to refuse the device-select byte, which is how acknowledge polling works. Early in the window the unit copies only the slots written in this transaction into the array, through a single-port write interface. Slots that were not written keep their old contents. While `busy` is high, all transaction inputs are ignored.

If the protect level is high when the stop arrives, the staged bytes are dropped without any write and `busy` stays low. Reads never pass through this block.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and no transaction bytes are staged.
- R2: `addr_set` loads the page from `addr_val[ADDR_W-1:3]` and the starting slot from `addr_val[2:0]`. Each accepted `data_stb` byte is stored in the current slot, and the slot pointer then advances by one.
- R3: The slot pointer wraps from 7 to 0 within the same page. A ninth or later byte replaces the byte staged earlier in that slot, and only the newest value is committed.
- R4: Only slots written since the last `addr_set` are committed. Every other address in the page sees no write.
- R5: A stop with one or more staged bytes and protect low raises `busy` on the next cycle. `busy` then stays high for exactly WC_CYCLES cycles and falls by itself.
- R6: Commit writes occur only while `busy` is high, within its first 8 cycles, at most one per cycle, in ascending slot order, to address {page, slot}.
- R7: While `busy` is high, `addr_set`, `data_stb` and `stop_stb` have no effect: they neither change the staged page, slot or bytes nor lengthen the busy window.
- R8: A stop while `wp_level` is high discards the staged bytes, produces no memory write and leaves `busy` low.
- R9: A stop with no staged bytes (a dummy write that only sets the address) leaves `busy` low and writes nothing.
- R10: A new `addr_set` before the stop discards the bytes staged under the previous address.
- R11: Once `busy` falls, the unit accepts a new transaction, and the slot pointer continues from where the previous one left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_set | input | 1 | Memory address word received, starts a new staging set |
| addr_val | input | ADDR_W | Memory address carried with `addr_set` |
| data_stb | input | 1 | One write data byte received |
| data_val | input | DATA_W | Data byte carried with `data_stb` |
| stop_stb | input | 1 | Stop condition seen on the bus |
| wp_level | input | 1 | Write-protect level, high protects the whole array |
| busy | output | 1 | Timed write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_data | output | DATA_W | Array write data |

## Verification
The case that is hardest to reach from the ports is a full transaction (address, byte and stop) arriving in the middle of a busy window. Nothing visible changes at that moment, so a check there would prove little. The bench therefore injects that traffic partway through a commit. After the window closes, it sends a lone data byte with no new address followed by a stop. The address that this byte lands on shows whether the page and slot pointer survived the ignored traffic. Page wrap and overwrite are driven from the vector table with starting slots near the top of the page and byte counts above eight.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // advance a slot pointer, wrapping inside one page
  function automatic int unsigned slot_next(input int unsigned idx,
                                            input int unsigned nslots);
    return (idx + 1) % nslots;
  endfunction

  // one-hot mask for a slot
  function automatic int unsigned slot_bit(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/pcu_slot_buf.sv
module pcu_slot_buf #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  addr_set,
  input  logic [ADDR_W-1:0]     addr_val,
  input  logic                  data_stb,
  input  logic [DATA_W-1:0]     data_val,
  input  logic                  drop,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [PG_W-1:0]       page,
  output logic [PAGE_BYTES-1:0] mask,
  output logic [DATA_W-1:0]     rd_data
);
  import pcu_pkg::*;

  logic [PG_W-1:0]       page_q;
  logic [IDX_W-1:0]      idx_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];

  // named events for the checks
  logic take_addr, take_byte;
  assign take_addr = accept && addr_set;
  assign take_byte = accept && !addr_set && data_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      idx_q  <= '0;
    end else if (take_addr) begin
      page_q <= addr_val[ADDR_W-1:IDX_W];
      idx_q  <= addr_val[IDX_W-1:0];
    end else if (take_byte) begin
      idx_q  <= IDX_W'(slot_next(int'(idx_q), PAGE_BYTES));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          mask_q <= '0;
    else if (drop)       mask_q <= '0;
    else if (take_addr)  mask_q <= '0;
    else if (take_byte)  mask_q <= mask_q | PAGE_BYTES'(slot_bit(int'(idx_q)));
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   slot_q[g] <= '0;
      else if (take_byte && idx_q == IDX_W'(g))     slot_q[g] <= data_val;
    end
  end

  assign page    = page_q;
  assign mask    = mask_q;
  assign rd_data = slot_q[rd_idx];

  // R3
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte && idx_q == IDX_W'(PAGE_BYTES-1) |=> idx_q == '0);

  // R2
  slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte && !drop |=> $countones(mask_q) >= 1);

endmodule

// File: rtl/pcu_wc_timer.sv
module pcu_wc_timer #(
  parameter int WC_CYCLES = 500,
  localparam int CNT_W    = $clog2(WC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WC_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign last = busy_q && cnt_q == '0;

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cnt_q != '0 |=> busy_q);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);

endmodule

// File: rtl/pcu_commit_walk.sv
module pcu_commit_walk #(
  parameter int PAGE_BYTES = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             act,
  output logic [IDX_W-1:0] idx
);
  logic             act_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      idx_q <= '0;
    end else if (act_q) begin
      if (idx_q == IDX_W'(PAGE_BYTES-1)) act_q <= 1'b0;
      else                               idx_q <= idx_q + 1'b1;
    end
  end

  assign act = act_q;
  assign idx = idx_q;

  // R6
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !start && idx_q != IDX_W'(PAGE_BYTES-1) |=> act_q && idx_q == $past(idx_q) + 1'b1);

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WC_CYCLES  = 500,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_set,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] data_val,
  input  logic              stop_stb,
  input  logic              wp_level,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  logic [PG_W-1:0]       page;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     rd_data;
  logic                  tmr_busy, tmr_last;
  logic                  walk_act;
  logic [IDX_W-1:0]      walk_idx;

  // named events
  logic stop_seen, start_commit, wp_discard, drop_set;
  assign stop_seen    = stop_stb && !tmr_busy;
  assign start_commit = stop_seen && !wp_level && (mask != '0);
  assign wp_discard   = stop_seen && wp_level;
  assign drop_set     = wp_discard || tmr_last;

  pcu_slot_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .accept(!tmr_busy),
    .addr_set(addr_set), .addr_val(addr_val),
    .data_stb(data_stb), .data_val(data_val),
    .drop(drop_set), .rd_idx(walk_idx),
    .page(page), .mask(mask), .rd_data(rd_data));

  pcu_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_commit),
    .busy(tmr_busy), .last(tmr_last));

  pcu_commit_walk #(.PAGE_BYTES(PAGE_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_commit),
    .act(walk_act), .idx(walk_idx));

  assign busy     = tmr_busy;
  assign mem_we   = walk_act && mask[walk_idx];
  assign mem_addr = {page, walk_idx};
  assign mem_data = rd_data;

  // R6
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> tmr_busy);

  // R5
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_busy) |-> $past(stop_stb) && !$past(wp_level));

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_discard |=> !tmr_busy && mask == '0);

  // R9
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen && mask == '0 |=> !tmr_busy);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy && !tmr_last |=> $stable(mask) && $stable(page));

endmodule

// File: tb/page_commit_unit_bench.sv
module page_commit_unit_bench;
  localparam int AW = 9;
  localparam int WC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_set = 1'b0;
  logic [AW-1:0] addr_val = '0;
  logic          data_stb = 1'b0;
  logic [7:0]    data_val = '0;
  logic          stop_stb = 1'b0;
  logic          wp_level = 1'b0;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;

  always #10 clk = ~clk;

  page_commit_unit #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(8), .WC_CYCLES(WC)) u_page_commit_unit (
    .clk(clk), .rst_n(rst_n), .addr_set(addr_set), .addr_val(addr_val),
    .data_stb(data_stb), .data_val(data_val), .stop_stb(stop_stb),
    .wp_level(wp_level), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data));

  int nchk = 0, nfail = 0;
  logic [7:0] obs_mem [512];
  logic [7:0] exp_mem [512];
  int wr_total = 0, order_bad = 0, age = 0, prev_slot = -1;

  // array model and write-order monitor
  always @(posedge clk) begin
    if (mem_we) begin
      obs_mem[mem_addr] <= mem_data;
      wr_total <= wr_total + 1;
      if (int'(mem_addr[2:0]) <= prev_slot || age >= 8) order_bad <= order_bad + 1;
      prev_slot <= int'(mem_addr[2:0]);
    end
    if (busy) age <= age + 1;
    else begin age <= 0; prev_slot <= -1; end
  end

  task automatic check_eq(input string req, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic t_addr(input logic [AW-1:0] a);
    @(negedge clk); addr_set = 1'b1; addr_val = a;
    @(negedge clk); addr_set = 1'b0;
  endtask

  task automatic t_byte(input logic [7:0] d);
    @(negedge clk); data_stb = 1'b1; data_val = d;
    @(negedge clk); data_stb = 1'b0;
  endtask

  task automatic t_stop();
    @(negedge clk); stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0;
  endtask

  // counts busy samples over a window; the stop was driven one negedge earlier
  task automatic busy_len(output int n);
    n = (busy === 1'b1) ? 1 : 0;
    for (int i = 0; i < WC + 12; i++) begin
      @(negedge clk);
      if (busy === 1'b1) n++;
    end
  endtask

  // vector: {wp[21], nbytes[20:17], addr[16:8], seed[7:0]}
  localparam logic [21:0] VEC [6] = '{
    {1'b0, 4'd3,  9'h013, 8'h10},
    {1'b0, 4'd4,  9'h1FE, 8'h40},
    {1'b0, 4'd8,  9'h040, 8'h80},
    {1'b0, 4'd11, 9'h085, 8'hC3},
    {1'b1, 4'd2,  9'h0C0, 8'h21},
    {1'b0, 4'd0,  9'h100, 8'h00}
  };

  initial begin
    for (int i = 0; i < 512; i++) begin
      obs_mem[i] = 8'hA5 ^ 8'(i);
      exp_mem[i] = 8'hA5 ^ 8'(i);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1 busy in reset", int'(busy), 0);
    check_eq("R1 mem_we in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 busy after reset", int'(busy), 0);
    t_stop();
    check_eq("R1 no staged bytes after reset", int'(busy), 0);

    // table walk: R2 R3 R4 R5 R6 R8 R9 R11
    foreach (VEC[v]) begin
      logic [AW-1:0] a;
      int n, bl, w0, ob0, expw;
      logic [7:0] sd;
      logic wpv;
      logic [7:0] seen;
      wpv = VEC[v][21]; n = int'(VEC[v][20:17]); a = VEC[v][16:8]; sd = VEC[v][7:0];
      wp_level = wpv;
      w0 = wr_total; ob0 = order_bad;
      seen = '0;
      t_addr(a);
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        int s;
        d = sd + 8'(k * 37);
        s = (int'(a[2:0]) + k) % 8;
        t_byte(d);
        if (!wpv) begin
          exp_mem[{a[AW-1:3], 3'(s)}] = d;
          seen[s] = 1'b1;
        end
      end
      t_stop();
      busy_len(bl);
      expw = $countones(seen);
      check_eq((wpv || n == 0) ? "R8/R9 busy length" : "R5 busy length", bl, (wpv || n == 0) ? 0 : WC);
      check_eq("R4 write count", wr_total - w0, expw);
      check_eq("R6 write order and window", order_bad - ob0, 0);
      for (int s = 0; s < 8; s++)
        check_eq("R2/R3 page content", int'(obs_mem[{a[AW-1:3], 3'(s)}]),
                 int'(exp_mem[{a[AW-1:3], 3'(s)}]));
      wp_level = 1'b0;
    end

    // R8: protected stop discarded the bytes; a later stop writes nothing
    begin
      int bl, w0;
      w0 = wr_total;
      wp_level = 1'b1;
      t_addr(9'h0E2); t_byte(8'h99);
      t_stop();
      wp_level = 1'b0;
      t_stop();
      busy_len(bl);
      check_eq("R8 stale bytes after protect", bl, 0);
      check_eq("R8 no write", wr_total - w0, 0);
    end

    // R10: new address discards earlier staged bytes
    begin
      int bl, w0;
      w0 = wr_total;
      t_addr(9'h0A0); t_byte(8'h11); t_byte(8'h22);
      t_addr(9'h0B3); t_byte(8'h33);
      t_stop();
      busy_len(bl);
      check_eq("R10 write count", wr_total - w0, 1);
      check_eq("R10 new byte", int'(obs_mem[9'h0B3]), 8'h33);
      check_eq("R10 old page untouched", int'(obs_mem[9'h0A0]), int'(exp_mem[9'h0A0]));
    end

    // R7: traffic during busy is ignored; R11: pointer continues afterwards
    begin
      int n, w0;
      w0 = wr_total;
      t_addr(9'h150); t_byte(8'h61); t_byte(8'h62);
      @(negedge clk); stop_stb = 1'b1;
      n = 0;
      for (int i = 0; i < WC + 12; i++) begin
        @(negedge clk);
        if (busy === 1'b1) n++;
        stop_stb = 1'b0; addr_set = 1'b0; data_stb = 1'b0;
        if (i == 3) begin addr_set = 1'b1; addr_val = 9'h1A0; end
        if (i == 4) begin data_stb = 1'b1; data_val = 8'h77; end
        if (i == 5) stop_stb = 1'b1;
      end
      check_eq("R7 busy not extended", n, WC);
      check_eq("R7 write count", wr_total - w0, 2);
      check_eq("R7 ignored byte absent", int'(obs_mem[9'h1A0]), int'(exp_mem[9'h1A0]));
      w0 = wr_total;
      t_byte(8'h55);
      t_stop();
      busy_len(n);
      check_eq("R11 busy for follow-up", n, WC);
      check_eq("R7 R11 pointer kept", int'(obs_mem[9'h152]), 8'h55);
      check_eq("R11 follow-up write count", wr_total - w0, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule